// File: doc/BRIEF.md
# USB Line State Event Detector

This block watches the two digitized receiver outputs of a USB data pair and reports what the bus is doing. It first synchronizes both lines into the local clock domain. It then accepts a line change only when two consecutive samples agree. The filtered pair is classified as J, K, single-ended zero or the illegal both-high state, with J and K swapped by a speed-select input. A run-length counter measures how long each classification has lasted.

On top of that classification the block derives a registered line-state code, one-cycle event pulses and two level flags. The pulses report start of packet, end of packet, resume, disconnect, connect and bus reset. The flags report whether a device is attached and whether a bus reset is in progress. All durations are in clock cycles, derived from a clock-frequency parameter. Two parameters choose between the long and the short limits for connect and reset.

Top module: `usb_line_monitor`

## Requirements
- R1: While reset is asserted and directly after it, `line_code_o` is 000, every event pulse is 0, and `connected_o` and `in_reset_o` are 0.
- R2: Each line passes through a two-flop synchronizer, and a new line pair is accepted only after two equal consecutive samples. A one-cycle input glitch changes no output.
- R3: With `low_speed_i`=0, `{dp_i,dm_i}` is coded as follows: 10 gives J (code 001), 01 gives K (code 010), 00 gives SE0 (code 000) and 11 gives SE1 (code 011). J held for at least IDLE_BITS bit times is reported as idle (code 100).
- R4: With `low_speed_i`=1, J and K swap: 01 is J/idle and 10 is K. All bit-time windows use the low-speed bit time.
- R5: `sop_o` pulses when the code moves from idle to K. A K that follows a J shorter than the idle time gives no pulse.
- R6: `eop_o` pulses once when both of the following hold. First, an SE0 run of half to two bit times (measured length minus one, inclusive) ends in J. Second, that J then lasts one bit time. Shorter or longer SE0 runs give no pulse.
- R7: `resume_o` pulses once per K run that lasts RESUME_BITS bit times.
- R8: While connected, SE0 lasting 2.5 µs pulses `disconnect_o` and clears `connected_o`.
- R9: While not connected, idle lasting 2 ms (CONN_FULL=1) or 2.5 µs (CONN_FULL=0) pulses `connect_o` and sets `connected_o`.
- R10: SE0 lasting 10 ms (RST_FULL=1) or 2.5 µs (RST_FULL=0) pulses `reset_o` and raises `in_reset_o`. The flag stays high until the line shows J or K.
- R11: SE1 gives no event pulse and leaves `connected_o` and `in_reset_o` unchanged.
- R12: Every event pulse lasts exactly one clock cycle per qualifying run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Digitized D+ receiver output |
| dm_i | input | 1 | Digitized D- receiver output |
| low_speed_i | input | 1 | 1 selects low-speed polarity and bit time |
| line_code_o | output | 3 | 000 SE0, 001 J, 010 K, 011 SE1, 100 idle |
| sop_o | output | 1 | Start-of-packet pulse |
| eop_o | output | 1 | End-of-packet pulse |
| resume_o | output | 1 | Resume pulse |
| disconnect_o | output | 1 | Disconnect pulse |
| connect_o | output | 1 | Connect pulse |
| reset_o | output | 1 | Bus reset pulse |
| connected_o | output | 1 | Device attached flag |
| in_reset_o | output | 1 | Bus reset in progress flag |

## Verification
The classifier is driven with all four line pairs at both speeds. This separates the J/K swap from a plain pass-through and shows that SE1 is coded but stays silent. SE0 runs of 4, 16, 60, 133, 400 and 600 cycles fall on each side of the end-of-packet window, the disconnect limit and the reset limit. K runs of 100 and 320 cycles do the same for resume, and the 320-cycle run also shows that a long run gives one pulse, not many. A K reached from a short J, set against one reached from idle, separates start of packet from any J-to-K edge. A single-cycle glitch shows that the two-sample filter holds.

// File: rtl/usb_lmon_pkg.sv
`timescale 1ns/1ps
package usb_lmon_pkg;

  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_e;

  localparam logic [2:0] CODE_SE0  = 3'd0;
  localparam logic [2:0] CODE_J    = 3'd1;
  localparam logic [2:0] CODE_K    = 3'd2;
  localparam logic [2:0] CODE_SE1  = 3'd3;
  localparam logic [2:0] CODE_IDLE = 3'd4;

  // Map a filtered line pair to a bus state; low speed swaps J and K.
  function automatic line_e classify(input logic dp, input logic dm, input logic ls);
    line_e r;
    unique case ({dp, dm})
      2'b00:   r = LN_SE0;
      2'b11:   r = LN_SE1;
      2'b10:   r = ls ? LN_K : LN_J;
      default: r = ls ? LN_J : LN_K;
    endcase
    return r;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/usb_lmon_sync.sv
`timescale 1ns/1ps
module usb_lmon_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] filt_o
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0][LANES-1:0] chain_q;
  logic [LANES-1:0]             sync_w;
  logic [LANES-1:0]             samp_q;
  logic [LANES-1:0]             filt_q, filt_d;
  logic                         agree_w;

  // metastability chain
  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], raw_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= raw_i;
      end
    end
  endgenerate

  assign sync_w  = chain_q[TOP];
  assign agree_w = (sync_w == samp_q);

  // two-sample acceptance filter
  always_comb begin
    filt_d = filt_q;
    if (agree_w) filt_d = sync_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      filt_q <= '0;
    end else begin
      samp_q <= sync_w;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_TWO_SAMPLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_o) |-> ($past(sync_w, 1) == $past(sync_w, 2))); // R2

endmodule

// File: rtl/usb_lmon_runlen.sv
`timescale 1ns/1ps
module usb_lmon_runlen
  import usb_lmon_pkg::*;
#(
  parameter int CW      = 20,
  parameter int CNT_MAX = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  line_e         state_i,
  output line_e         cur_o,
  output logic [CW-1:0] cnt_o,
  output logic          chg_o,
  output line_e         prev_o,
  output logic [CW-1:0] prev_len_o
);

  localparam logic [CW-1:0] SAT = CW'(CNT_MAX);

  line_e         cur_q, cur_d, prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d, plen_q, plen_d;
  logic          chg_q, chg_d;
  logic          diff_w, cnt_en_w;

  assign diff_w   = (state_i != cur_q);
  assign cnt_en_w = !diff_w && (cnt_q != SAT);

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    plen_d = plen_q;
    cnt_d  = cnt_q;
    chg_d  = 1'b0;
    if (diff_w) begin
      cur_d  = state_i;
      prev_d = cur_q;
      plen_d = cnt_q;
      cnt_d  = '0;
      chg_d  = 1'b1;
    end else if (cnt_en_w) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= LN_SE0;
      prev_q <= LN_SE0;
      plen_q <= '0;
      cnt_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      plen_q <= plen_d;
      cnt_q  <= cnt_d;
      chg_q  <= chg_d;
    end
  end

  assign cur_o      = cur_q;
  assign prev_o     = prev_q;
  assign prev_len_o = plen_q;
  assign cnt_o      = cnt_q;
  assign chg_o      = chg_q;

  AST_RUN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_o) |-> (cnt_o == '0) && chg_o); // R6

endmodule

// File: rtl/usb_lmon_events.sv
`timescale 1ns/1ps
module usb_lmon_events
  import usb_lmon_pkg::*;
#(
  parameter int CW          = 20,
  parameter int FS_BIT      = 4,
  parameter int LS_BIT      = 32,
  parameter int IDLE_BITS   = 2,
  parameter int RESUME_BITS = 16,
  parameter int DISC_CYC    = 120,
  parameter int CONN_CYC    = 96000,
  parameter int RST_CYC     = 480000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ls_i,
  input  line_e         cur_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          chg_i,
  input  line_e         prev_i,
  input  logic [CW-1:0] prev_len_i,
  output logic [2:0]    code_o,
  output logic          sop_o,
  output logic          eop_o,
  output logic          resume_o,
  output logic          disconnect_o,
  output logic          connect_o,
  output logic          reset_o,
  output logic          connected_o,
  output logic          in_reset_o
);

  localparam logic [CW-1:0] BIT_FS  = CW'(FS_BIT);
  localparam logic [CW-1:0] BIT_LS  = CW'(LS_BIT);
  localparam logic [CW-1:0] IDLE_FS = CW'(IDLE_BITS * FS_BIT);
  localparam logic [CW-1:0] IDLE_LS = CW'(IDLE_BITS * LS_BIT);
  localparam logic [CW-1:0] RES_FS  = CW'(RESUME_BITS * FS_BIT);
  localparam logic [CW-1:0] RES_LS  = CW'(RESUME_BITS * LS_BIT);
  localparam logic [CW-1:0] DISC_TH = CW'(DISC_CYC);
  localparam logic [CW-1:0] CONN_TH = CW'(CONN_CYC);
  localparam logic [CW-1:0] RST_TH  = CW'(RST_CYC);

  // speed-dependent windows
  logic [CW-1:0] bit_w, idle_w, res_w, eop_lo_w, eop_hi_w;
  assign bit_w    = ls_i ? BIT_LS  : BIT_FS;
  assign idle_w   = ls_i ? IDLE_LS : IDLE_FS;
  assign res_w    = ls_i ? RES_LS  : RES_FS;
  assign eop_lo_w = bit_w >> 1;
  assign eop_hi_w = bit_w << 1;

  logic [2:0] code_q, code_d;
  logic       arm_q, arm_d;
  logic       conn_q, conn_d;
  logic       inrst_q, inrst_d;
  logic       sop_q, eop_q, res_q, disc_q, cev_q, rev_q;
  logic       sop_d, eop_d, res_d, disc_d, cev_d, rev_d;
  logic       se0_fits_w, is_data_w;

  // line-state code
  always_comb begin
    unique case (cur_i)
      LN_SE0:  code_d = CODE_SE0;
      LN_J:    code_d = (cnt_i >= idle_w) ? CODE_IDLE : CODE_J;
      LN_K:    code_d = CODE_K;
      default: code_d = CODE_SE1;
    endcase
  end

  assign se0_fits_w = (prev_i == LN_SE0) && (prev_len_i >= eop_lo_w) &&
                      (prev_len_i <= eop_hi_w);
  assign is_data_w  = (cur_i == LN_J) || (cur_i == LN_K);

  // event sequencing
  always_comb begin
    sop_d  = (code_d == CODE_K) && (code_q == CODE_IDLE);
    eop_d  = arm_q && (cur_i == LN_J) && (cnt_i == bit_w - 1'b1);
    res_d  = (cur_i == LN_K) && (cnt_i == res_w);
    disc_d = conn_q && (cur_i == LN_SE0) && (cnt_i == DISC_TH);
    cev_d  = !conn_q && (cur_i == LN_J) && (cnt_i == CONN_TH);
    rev_d  = (cur_i == LN_SE0) && (cnt_i == RST_TH);

    arm_d = arm_q;
    if (chg_i)      arm_d = (cur_i == LN_J) && se0_fits_w;
    else if (eop_d) arm_d = 1'b0;

    conn_d = conn_q;
    if (disc_d)     conn_d = 1'b0;
    else if (cev_d) conn_d = 1'b1;

    inrst_d = inrst_q;
    if (rev_d)          inrst_d = 1'b1;
    else if (is_data_w) inrst_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= CODE_SE0;
      arm_q   <= 1'b0;
      conn_q  <= 1'b0;
      inrst_q <= 1'b0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
      res_q   <= 1'b0;
      disc_q  <= 1'b0;
      cev_q   <= 1'b0;
      rev_q   <= 1'b0;
    end else begin
      code_q  <= code_d;
      arm_q   <= arm_d;
      conn_q  <= conn_d;
      inrst_q <= inrst_d;
      sop_q   <= sop_d;
      eop_q   <= eop_d;
      res_q   <= res_d;
      disc_q  <= disc_d;
      cev_q   <= cev_d;
      rev_q   <= rev_d;
    end
  end

  assign code_o       = code_q;
  assign sop_o        = sop_q;
  assign eop_o        = eop_q;
  assign resume_o     = res_q;
  assign disconnect_o = disc_q;
  assign connect_o    = cev_q;
  assign reset_o      = rev_q;
  assign connected_o  = conn_q;
  assign in_reset_o   = inrst_q;

  AST_IDLE_FROM_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CODE_IDLE) |-> ($past(cur_i) == LN_J)); // R3
  AST_SE1_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i == LN_SE1) |=> !(sop_o || eop_o || resume_o || disconnect_o || connect_o || reset_o)); // R11
  AST_DISC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_o |-> !connected_o); // R8
  AST_CONN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    connect_o |-> connected_o); // R9
  AST_RESET_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> in_reset_o); // R10
  AST_SOP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |=> !sop_o); // R12
  AST_RESUME_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o); // R12

endmodule

// File: rtl/usb_line_monitor.sv
`timescale 1ns/1ps
module usb_line_monitor
  import usb_lmon_pkg::*;
#(
  parameter int CLK_HZ      = 48_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS   = 2,
  parameter int RESUME_BITS = 16,
  parameter bit CONN_FULL   = 1'b1,
  parameter bit RST_FULL    = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       low_speed_i,
  output logic [2:0] line_code_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       resume_o,
  output logic       disconnect_o,
  output logic       connect_o,
  output logic       reset_o,
  output logic       connected_o,
  output logic       in_reset_o
);

  localparam int FS_BIT   = CLK_HZ / 12_000_000;
  localparam int LS_BIT   = CLK_HZ / 1_500_000;
  localparam int SHORT_TO = CLK_HZ / 400_000;
  localparam int DISC_CYC = SHORT_TO;
  localparam int CONN_CYC = CONN_FULL ? (CLK_HZ / 500) : SHORT_TO;
  localparam int RST_CYC  = RST_FULL  ? (CLK_HZ / 100) : SHORT_TO;
  localparam int LONGEST  = max2(max2(CONN_CYC, RST_CYC),
                                 max2(RESUME_BITS * LS_BIT, 2 * max2(IDLE_BITS, 2) * LS_BIT));
  localparam int CNT_MAX  = LONGEST + 1;
  localparam int CW       = $clog2(CNT_MAX + 1);

  logic [1:0]    filt_w;
  line_e         state_w, cur_w, prev_w;
  logic [CW-1:0] cnt_w, plen_w;
  logic          chg_w;

  usb_lmon_sync #(
    .LANES  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({dp_i, dm_i}),
    .filt_o (filt_w)
  );

  assign state_w = classify(filt_w[1], filt_w[0], low_speed_i);

  usb_lmon_runlen #(
    .CW      (CW),
    .CNT_MAX (CNT_MAX)
  ) u_runlen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state_w),
    .cur_o      (cur_w),
    .cnt_o      (cnt_w),
    .chg_o      (chg_w),
    .prev_o     (prev_w),
    .prev_len_o (plen_w)
  );

  usb_lmon_events #(
    .CW          (CW),
    .FS_BIT      (FS_BIT),
    .LS_BIT      (LS_BIT),
    .IDLE_BITS   (IDLE_BITS),
    .RESUME_BITS (RESUME_BITS),
    .DISC_CYC    (DISC_CYC),
    .CONN_CYC    (CONN_CYC),
    .RST_CYC     (RST_CYC)
  ) u_events (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ls_i         (low_speed_i),
    .cur_i        (cur_w),
    .cnt_i        (cnt_w),
    .chg_i        (chg_w),
    .prev_i       (prev_w),
    .prev_len_i   (plen_w),
    .code_o       (line_code_o),
    .sop_o        (sop_o),
    .eop_o        (eop_o),
    .resume_o     (resume_o),
    .disconnect_o (disconnect_o),
    .connect_o    (connect_o),
    .reset_o      (reset_o),
    .connected_o  (connected_o),
    .in_reset_o   (in_reset_o)
  );

endmodule

// File: tb/usb_line_monitor_bench.sv
`timescale 1ns/1ps
module usb_line_monitor_bench;

  logic clk;
  logic rst_n;
  logic dp, dm, ls;
  logic [2:0] code;
  logic sop, eop, res, disc, conn_ev, rst_ev, connected, in_rst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int ev_tot[6] = '{0, 0, 0, 0, 0, 0};
  int ev_base[6] = '{0, 0, 0, 0, 0, 0};

  localparam int E_SOP = 0, E_EOP = 1, E_RES = 2, E_DISC = 3, E_CONN = 4, E_RST = 5;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // 200 MHz: FS bit 16, LS bit 133, 2.5 us = 500 cycles
  usb_line_monitor #(
    .CLK_HZ    (200_000_000),
    .CONN_FULL (1'b0),
    .RST_FULL  (1'b0)
  ) u_usb_line_monitor (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .dp_i         (dp),
    .dm_i         (dm),
    .low_speed_i  (ls),
    .line_code_o  (code),
    .sop_o        (sop),
    .eop_o        (eop),
    .resume_o     (res),
    .disconnect_o (disc),
    .connect_o    (conn_ev),
    .reset_o      (rst_ev),
    .connected_o  (connected),
    .in_reset_o   (in_rst)
  );

  always @(posedge clk) begin
    ev_tot[E_SOP]  <= ev_tot[E_SOP]  + int'(sop);
    ev_tot[E_EOP]  <= ev_tot[E_EOP]  + int'(eop);
    ev_tot[E_RES]  <= ev_tot[E_RES]  + int'(res);
    ev_tot[E_DISC] <= ev_tot[E_DISC] + int'(disc);
    ev_tot[E_CONN] <= ev_tot[E_CONN] + int'(conn_ev);
    ev_tot[E_RST]  <= ev_tot[E_RST]  + int'(rst_ev);
  end

  task automatic mark();
    for (int i = 0; i < 6; i++) ev_base[i] = ev_tot[i];
  endtask

  function automatic int ev(input int i);
    return ev_tot[i] - ev_base[i];
  endfunction

  function automatic int ev_all();
    int s = 0;
    for (int i = 0; i < 6; i++) s += ev(i);
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic p, input logic m, input int n);
    dp = p;
    dm = m;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ls = 1'b0; dp = 1'b1; dm = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 code in reset", int'(code), 0);
    chk("R1 flags in reset", int'({connected, in_rst}), 0);
    chk("R1 pulses in reset", int'({sop, eop, res, disc, conn_ev, rst_ev}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after release", int'(code), 0);
    chk("R1 connected after release", int'(connected), 0);
  endtask

  task automatic t_connect();
    mark();
    hold(1, 0, 12);
    chk("R3 short J code", int'(code), 1);
    hold(1, 0, 600);
    chk("R3 idle code", int'(code), 4);
    chk("R9 connect pulses", ev(E_CONN), 1);
    chk("R9 connected flag", int'(connected), 1);
  endtask

  task automatic t_glitch();
    mark();
    hold(0, 0, 1);
    hold(1, 0, 20);
    chk("R2 glitch code", int'(code), 4);
    chk("R2 glitch events", ev_all(), 0);
  endtask

  task automatic t_packet_fs();
    mark();
    hold(0, 1, 20);
    chk("R3 K code", int'(code), 2);
    chk("R5 sop from idle", ev(E_SOP), 1);
    hold(0, 0, 16);
    chk("R3 SE0 code", int'(code), 0);
    hold(1, 0, 60);
    chk("R6 eop after 1-bit SE0", ev(E_EOP), 1);
    chk("R3 idle after eop", int'(code), 4);
  endtask

  task automatic t_no_packet();
    mark();
    hold(0, 0, 60);
    hold(1, 0, 10);
    hold(0, 1, 20);
    chk("R5 no sop from short J", ev(E_SOP), 0);
    hold(0, 0, 4);
    hold(1, 0, 60);
    chk("R6 no eop on long or short SE0", ev(E_EOP), 0);
  endtask

  task automatic t_resume();
    mark();
    hold(0, 1, 100);
    hold(1, 0, 60);
    chk("R7 short K no resume", ev(E_RES), 0);
    mark();
    hold(0, 1, 320);
    chk("R7 R12 long K one resume", ev(E_RES), 1);
    hold(1, 0, 60);
  endtask

  task automatic t_se1();
    mark();
    hold(1, 1, 700);
    chk("R3 SE1 code", int'(code), 3);
    chk("R11 SE1 events", ev_all(), 0);
    chk("R11 SE1 connected kept", int'(connected), 1);
    chk("R11 SE1 in_reset kept", int'(in_rst), 0);
    hold(1, 0, 60);
    chk("R11 leaving SE1 events", ev_all(), 0);
  endtask

  task automatic t_disc_reset();
    mark();
    hold(0, 0, 400);
    chk("R8 short SE0 no disconnect", ev(E_DISC), 0);
    chk("R10 short SE0 no reset", ev(E_RST), 0);
    chk("R8 still connected", int'(connected), 1);
    hold(1, 0, 40);
    mark();
    hold(0, 0, 600);
    chk("R8 disconnect pulse", ev(E_DISC), 1);
    chk("R8 connected cleared", int'(connected), 0);
    chk("R10 reset pulse", ev(E_RST), 1);
    chk("R10 in_reset high", int'(in_rst), 1);
    chk("R3 SE0 code long", int'(code), 0);
    hold(1, 0, 20);
    chk("R10 in_reset cleared by J", int'(in_rst), 0);
    mark();
    hold(1, 0, 600);
    chk("R9 reconnect pulse", ev(E_CONN), 1);
    chk("R9 reconnected", int'(connected), 1);
  endtask

  task automatic t_low_speed();
    ls = 1'b1;
    hold(0, 1, 400);
    chk("R4 LS idle code", int'(code), 4);
    mark();
    hold(1, 0, 30);
    chk("R4 LS K code", int'(code), 2);
    chk("R4 R5 LS sop", ev(E_SOP), 1);
    hold(0, 0, 133);
    hold(0, 1, 300);
    chk("R4 R6 LS eop", ev(E_EOP), 1);
    mark();
    hold(1, 0, 30);
    hold(0, 0, 16);
    hold(0, 1, 300);
    chk("R4 R6 FS-length SE0 at LS no eop", ev(E_EOP), 0);
    chk("R4 LS connected kept", int'(connected), 1);
  endtask

  initial begin
    t_reset();
    t_connect();
    t_glitch();
    t_packet_fs();
    t_no_packet();
    t_resume();
    t_se1();
    t_disc_reset();
    t_low_speed();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule